// File: doc/BRIEF.md
# LCD contrast PWM generator

This block drives one pulse-width-modulated line that sets the contrast of an LCD panel. A 16-bit control word is written and read through a plain synchronous port. The word carries an enable flag, a two-bit code that chooses which LCD timing strobe moves the counter, and an 8-bit pulse width.

An internal 8-bit counter takes one step per strobe of the chosen source. The output is high while the count is below the active width, so one period lasts 256 strobes. The three strobes are single-cycle pulses in the system clock domain. No prescaler is involved, so the PWM frequency is the strobe rate divided by 256.

A width written in the middle of a period is held back until the counter wraps. This keeps every period whole.

Top module: `lcd_contrast_pwm`

## Requirements
- R1: After reset the read port returns 0x0000 and the output is low.
- R2: A write stores the word. A read returns it with bits 15 to 11 forced to 0. Bit 8 is the enable, bits 10 to 9 are the source code, and bits 7 to 0 are the width.
- R3: While the enable bit is 0, the output is low, strobes have no effect, and the counter sits at 0.
- R4: Source code 00 selects the line strobe, 01 the pixel strobe and 10 the LCD clock strobe. Each strobe of the selected source moves the counter up by one. Strobes of the other two sources are ignored.
- R5: With source code 11 the counter keeps its value and the output is low. Choosing a valid code again resumes counting from that held value.
- R6: While enabled with a valid source, the output is high exactly when the count is below the active width. A width of 0 keeps the output low. A width of 255 gives 255 high counts out of every 256.
- R7: A width written while enabled becomes active only when the counter steps from 255 to 0. A width written together with a change of the enable bit is active at once.
- R8: After the enable bit goes from 0 to 1, counting starts at 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Control word to write |
| cfg_rdata | output | 16 | Stored control word |
| line_stb | input | 1 | Line timing strobe, one cycle wide |
| pix_stb | input | 1 | Pixel timing strobe, one cycle wide |
| lclk_stb | input | 1 | LCD clock strobe, one cycle wide |
| contrast_pwm | output | 1 | Contrast PWM output |

## Verification
The count cannot be read at the ports, but the output is a direct function of it. A wrong count therefore appears at the pin on the first strobe whose compare result differs from the expected one. Sweeping several widths over two full periods on every source catches such an error within one strobe.

A strobe from the wrong source moving the counter, a lost hold on the reserved code, or a width loaded early shows up as an output edge that lands in the wrong strobe. The counting that follows then stays off by that offset for the rest of the period.

// File: rtl/lcd_contrast_pwm.sv
module lcd_contrast_pwm (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        line_stb,
  input  logic        pix_stb,
  input  logic        lclk_stb,
  output logic        contrast_pwm
);
  localparam int CW = 8;
  localparam int EN_BIT = 8;
  localparam int SRC_LSB = 9;
  localparam logic [CW-1:0] TOP = '1;
  localparam logic [1:0] SRC_LINE = 2'b00;
  localparam logic [1:0] SRC_PIX  = 2'b01;
  localparam logic [1:0] SRC_LCLK = 2'b10;
  localparam logic [1:0] SRC_NONE = 2'b11;

  logic          en_q, en_d;
  logic [1:0]    src_q, src_d;
  logic [CW-1:0] wid_q, wid_d, act_q, cnt_q;
  logic          tick, wrap;

  assign en_d  = cfg_we ? cfg_wdata[EN_BIT] : en_q;
  assign src_d = cfg_we ? cfg_wdata[SRC_LSB +: 2] : src_q;
  assign wid_d = cfg_we ? cfg_wdata[CW-1:0] : wid_q;

  always_comb begin
    case (src_q)
      SRC_LINE: tick = line_stb;
      SRC_PIX:  tick = pix_stb;
      SRC_LCLK: tick = lclk_stb;
      default:  tick = 1'b0;
    endcase
  end

  assign wrap = en_q && tick && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      src_q <= SRC_LINE;
      wid_q <= '0;
      act_q <= '0;
      cnt_q <= '0;
    end else begin
      en_q  <= en_d;
      src_q <= src_d;
      wid_q <= wid_d;
      if (!en_d)
        cnt_q <= '0;
      else if (en_q && tick)
        cnt_q <= cnt_q + 1'b1;
      if (!en_q || !en_d)
        act_q <= wid_d;
      else if (wrap)
        act_q <= wid_q;
    end
  end

  assign cfg_rdata    = {5'b0, src_q, en_q, wid_q};
  assign contrast_pwm = en_q && (src_q != SRC_NONE) && (cnt_q < act_q);

  p_rdback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & 16'h07FF));

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[EN_BIT] |-> (cnt_q == '0) && !contrast_pwm);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick && !cfg_we) |=> cnt_q == $past(cnt_q) + 1'b1);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && src_q == SRC_NONE && !cfg_we) |=> $stable(cnt_q) && !contrast_pwm);

  p_zero_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q == '0) |-> !contrast_pwm);

  p_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cfg_we && cfg_wdata[EN_BIT] && !wrap) |=> $stable(act_q));
endmodule

// File: tb/lcd_contrast_pwm_tb.sv
`timescale 1ns/1ps
module lcd_contrast_pwm_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic line_stb = 1'b0, pix_stb = 1'b0, lclk_stb = 1'b0;
  logic contrast_pwm;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lcd_contrast_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .line_stb(line_stb), .pix_stb(pix_stb),
    .lclk_stb(lclk_stb), .contrast_pwm(contrast_pwm));

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s pwm got %0b exp %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk16(input logic [15:0] got, input logic [15:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s rdata got %h exp %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic tick(input logic l, input logic p, input logic c);
    line_stb = l; pix_stb = p; lclk_stb = c;
    @(negedge clk);
    line_stb = 1'b0; pix_stb = 1'b0; lclk_stb = 1'b0;
  endtask

  task automatic sel(input int s);
    tick(s == 0, s == 1, s == 2);
  endtask

  function automatic logic [15:0] word(input bit en, input int s, input int w);
    return 16'(((en ? 1 : 0) << 8) | (s << 9) | (w & 255));
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int widths[6] = '{0, 1, 2, 128, 254, 255};
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk16(cfg_rdata, 16'h0000, "R1");
    chk(contrast_pwm, 1'b0, "R1");

    wr(16'hFFFF);
    chk16(cfg_rdata, 16'h07FF, "R2");
    chk(contrast_pwm, 1'b0, "R5");
    wr(16'h0000);
    chk16(cfg_rdata, 16'h0000, "R2");
    for (int i = 0; i < 5; i++) begin
      tick(1, 1, 1);
      chk(contrast_pwm, 1'b0, "R3");
    end

    // R4 R6 R8: sweep of sources and widths over two periods
    for (int s = 0; s < 3; s++) begin
      foreach (widths[i]) begin
        wr(16'h0000);
        wr(word(1, s, widths[i]));
        chk16(cfg_rdata, word(1, s, widths[i]), "R2");
        chk(contrast_pwm, 0 < widths[i], "R8");
        for (int j = 1; j <= 512; j++) begin
          if (j % 7 == 0) begin
            tick(s != 0, s != 1, s != 2);
            chk(contrast_pwm, ((j - 1) % 256) < widths[i], "R4");
          end
          sel(s);
          chk(contrast_pwm, (j % 256) < widths[i], "R6");
        end
      end
    end

    // R7: width change mid-period waits for the wrap
    wr(16'h0000);
    wr(word(1, 0, 10));
    for (int j = 0; j < 5; j++) sel(0);
    wr(word(1, 0, 200));
    chk16(cfg_rdata, word(1, 0, 200), "R2");
    chk(contrast_pwm, 1'b1, "R7");
    k = 5;
    while (k < 20) begin sel(0); k++; end
    chk(contrast_pwm, 1'b0, "R7");
    while (k < 256) begin sel(0); k++; end
    chk(contrast_pwm, 1'b1, "R7");
    for (int j = 1; j <= 255; j++) begin
      sel(0);
      chk(contrast_pwm, j < 200, "R7");
    end

    // R5: reserved code holds the count
    wr(16'h0000);
    wr(word(1, 1, 4));
    for (int j = 0; j < 3; j++) sel(1);
    chk(contrast_pwm, 1'b1, "R6");
    wr(word(1, 3, 4));
    chk(contrast_pwm, 1'b0, "R5");
    for (int j = 0; j < 10; j++) begin
      tick(1, 1, 1);
      chk(contrast_pwm, 1'b0, "R5");
    end
    wr(word(1, 1, 4));
    chk(contrast_pwm, 1'b1, "R5");
    sel(1);
    chk(contrast_pwm, 1'b0, "R5");

    // R3 R8: disable mid-count, then re-enable from zero
    wr(16'h0000);
    wr(word(1, 2, 3));
    for (int j = 0; j < 2; j++) sel(2);
    chk(contrast_pwm, 1'b1, "R6");
    wr(word(0, 2, 3));
    chk(contrast_pwm, 1'b0, "R3");
    for (int j = 0; j < 4; j++) begin
      tick(1, 1, 1);
      chk(contrast_pwm, 1'b0, "R3");
    end
    wr(word(1, 2, 1));
    chk(contrast_pwm, 1'b1, "R8");
    sel(2);
    chk(contrast_pwm, 1'b0, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule